// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Two component guessers work side by side. One keys a table of 2-bit counters by a shift register holding the directions of the most recent resolved branches, across all branches. The other first looks up a per-branch record of that branch's own recent directions, then uses that record to pick a 3-bit counter. A third table of 2-bit counters, one per branch slot, decides which of the two to believe.

The front end presents a fetch address and reads the final guess and both component guesses in the same cycle; the read path is purely combinational. When a branch resolves, the back end returns its address, its real direction and the two component guesses that were made for it. Every table and history register changes only on that resolve. Table sizes are parameters. The defaults give a 4096-entry selector, a 12-bit global history, 1024 local history records of 10 bits and 1024 local counters, about 29K bits in total.

Top module: `branch_dir_tournament`

## Requirements
- R1: `pred_taken` equals `pred_global` when the selector counter at the fetch address has its MSB set (value 2 or 3), and `pred_local` otherwise.
- R2: The selector counter is chosen by address bits [SEL_IDX_W+1:2]. On a resolve it steps up by one (saturating at 3) when `rs_pred_global` matches `rs_taken` and `rs_pred_local` does not. It steps down by one (saturating at 0) in the opposite case. It holds when both component guesses match the outcome or both miss.
- R3: The global counter is chosen by the current global history. It predicts taken when its MSB is 1. On a resolve it steps up on taken and down on not taken, saturating at 0 and 3.
- R4: The local history record is chosen by address bits [LHT_IDX_W+1:2]. On a resolve it shifts left by one, and the outcome enters bit 0 (1 = taken).
- R5: The local 3-bit counter is chosen by the local history record of the branch. It predicts taken when its MSB is 1. On a resolve it steps up on taken and down on not taken, saturating at 0 and 7.
- R6: On every resolve the global history shifts left by one, and the outcome enters bit 0.
- R7: When `rs_valid` is low no state changes. Presenting fetch addresses has no side effect, so predictions at any address stay the same until a resolve occurs.
- R8: After reset every 2-bit global counter holds 1 and every 3-bit counter holds 3, both weakly not taken. Every selector holds 1, weakly favouring local. All histories are zero. Every prediction output is therefore 0.
- R9: A prediction and a resolve in the same cycle are allowed. The prediction reflects the state before that resolve, and the resolve takes effect at the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fe_pc | input | PC_W | Fetch address to predict |
| pred_taken | output | 1 | Final direction guess, 1 = taken |
| pred_global | output | 1 | Global-history component guess |
| pred_local | output | 1 | Local-history component guess |
| rs_valid | input | 1 | A branch resolves this cycle |
| rs_pc | input | PC_W | Address of the resolving branch |
| rs_taken | input | 1 | Actual direction of the resolving branch |
| rs_pred_global | input | 1 | Global guess made for that branch |
| rs_pred_local | input | 1 | Local guess made for that branch |

## Verification
A corrupted counter or history is invisible at first. It shows only when the address or history that selects it is next presented, and often only as a wrong component bit while the final guess stays right. The bench therefore compares all three prediction outputs at every step against an independent table model. That catches a fault in the first cycle in which the bad entry is read, instead of waiting for a final-guess mismatch. Sequences are chosen so that histories wrap and counters reach both saturation limits, and a forced-disagreement phase drives the selector past its midpoint in both directions.

// File: rtl/branch_dir_tournament.sv
module branch_dir_tournament #(
  parameter int PC_W      = 32,
  parameter int SEL_IDX_W = 12,
  parameter int GHIST_W   = 12,
  parameter int LHT_IDX_W = 10,
  parameter int LHIST_W   = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] fe_pc,
  output logic            pred_taken,
  output logic            pred_global,
  output logic            pred_local,
  input  logic            rs_valid,
  input  logic [PC_W-1:0] rs_pc,
  input  logic            rs_taken,
  input  logic            rs_pred_global,
  input  logic            rs_pred_local
);
  localparam int SEL_N  = 1 << SEL_IDX_W;
  localparam int GCTR_N = 1 << GHIST_W;
  localparam int LHT_N  = 1 << LHT_IDX_W;
  localparam int LCTR_N = 1 << LHIST_W;

  logic [1:0]         sel_q  [SEL_N];
  logic [1:0]         gctr_q [GCTR_N];
  logic [LHIST_W-1:0] lht_q  [LHT_N];
  logic [2:0]         lctr_q [LCTR_N];
  logic [GHIST_W-1:0] ghist_q;

  function automatic logic [1:0] step2(input logic [1:0] c, input logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    else    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  function automatic logic [2:0] step3(input logic [2:0] c, input logic up);
    if (up) return (c == 3'd7) ? c : c + 3'd1;
    else    return (c == 3'd0) ? c : c - 3'd1;
  endfunction

  wire [SEL_IDX_W-1:0] fe_sel_idx = fe_pc[SEL_IDX_W+1:2];
  wire [LHT_IDX_W-1:0] fe_lht_idx = fe_pc[LHT_IDX_W+1:2];
  wire [LHIST_W-1:0]   fe_lhist   = lht_q[fe_lht_idx];

  assign pred_global = gctr_q[ghist_q][1];
  assign pred_local  = lctr_q[fe_lhist][2];
  assign pred_taken  = sel_q[fe_sel_idx][1] ? pred_global : pred_local;

  wire [SEL_IDX_W-1:0] rs_sel_idx = rs_pc[SEL_IDX_W+1:2];
  wire [LHT_IDX_W-1:0] rs_lht_idx = rs_pc[LHT_IDX_W+1:2];
  wire [LHIST_W-1:0]   rs_lhist   = lht_q[rs_lht_idx];
  wire                 sel_move   = rs_pred_global != rs_pred_local;
  wire                 sel_up     = rs_pred_global == rs_taken;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SEL_N; i++)  sel_q[i]  <= 2'd1;
      for (int i = 0; i < GCTR_N; i++) gctr_q[i] <= 2'd1;
      for (int i = 0; i < LHT_N; i++)  lht_q[i]  <= '0;
      for (int i = 0; i < LCTR_N; i++) lctr_q[i] <= 3'd3;
      ghist_q <= '0;
    end else if (rs_valid) begin
      gctr_q[ghist_q]    <= step2(gctr_q[ghist_q], rs_taken);
      lctr_q[rs_lhist]   <= step3(lctr_q[rs_lhist], rs_taken);
      lht_q[rs_lht_idx]  <= {rs_lhist[LHIST_W-2:0], rs_taken};
      ghist_q            <= {ghist_q[GHIST_W-2:0], rs_taken};
      if (sel_move)
        sel_q[rs_sel_idx] <= step2(sel_q[rs_sel_idx], sel_up);
    end
  end
endmodule

// File: rtl/branch_dir_tournament_chk.sv
module branch_dir_tournament_chk #(
  parameter int PC_W    = 32,
  parameter int GHIST_W = 12
) (
  input logic               clk,
  input logic               rst,
  input logic [PC_W-1:0]    fe_pc,
  input logic               pred_taken,
  input logic               pred_global,
  input logic               pred_local,
  input logic               rs_valid,
  input logic               rs_taken,
  input logic [GHIST_W-1:0] ghist
);
  // R1
  agree_passes_chk: assert property (@(posedge clk) disable iff (rst)
    (pred_global == pred_local) |-> (pred_taken == pred_global));

  // R6
  ghist_newest_chk: assert property (@(posedge clk) disable iff (rst)
    rs_valid |=> (ghist[0] == $past(rs_taken)));

  // R6
  ghist_shift_chk: assert property (@(posedge clk) disable iff (rst)
    rs_valid |=> (ghist[GHIST_W-1:1] == $past(ghist[GHIST_W-2:0])));

  // R7
  ghist_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rs_valid |=> $stable(ghist));

  // R7
  pred_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rs_valid |=> ($stable(fe_pc) -> ($stable(pred_taken) && $stable(pred_global) && $stable(pred_local))));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (ghist == '0));
endmodule

bind branch_dir_tournament branch_dir_tournament_chk #(.PC_W(PC_W), .GHIST_W(GHIST_W)) u_chk (
  .clk(clk), .rst(rst), .fe_pc(fe_pc), .pred_taken(pred_taken),
  .pred_global(pred_global), .pred_local(pred_local), .rs_valid(rs_valid),
  .rs_taken(rs_taken), .ghist(ghist_q)
);

// File: tb/branch_dir_tournament_tb.sv
`timescale 1ns/1ps
module branch_dir_tournament_tb;
  localparam int PC_W = 16;
  logic clk = 0, rst = 1;
  logic [PC_W-1:0] fe_pc = '0, rs_pc = '0;
  logic rs_valid = 0, rs_taken = 0, rs_pred_global = 0, rs_pred_local = 0;
  logic pred_taken, pred_global, pred_local;
  int total = 0, fails = 0;

  branch_dir_tournament #(.PC_W(PC_W), .SEL_IDX_W(4), .GHIST_W(3), .LHT_IDX_W(2), .LHIST_W(3)) u_dut (
    .clk(clk), .rst(rst), .fe_pc(fe_pc), .pred_taken(pred_taken), .pred_global(pred_global),
    .pred_local(pred_local), .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken),
    .rs_pred_global(rs_pred_global), .rs_pred_local(rs_pred_local));

  always #4 clk = ~clk;

  // reference tables, sized for the reduced setting
  int m_sel[16], m_g[8], m_lht[4], m_l[8], m_gh;

  task automatic m_reset();
    foreach (m_sel[i]) m_sel[i] = 1;
    foreach (m_g[i]) m_g[i] = 1;
    foreach (m_lht[i]) m_lht[i] = 0;
    foreach (m_l[i]) m_l[i] = 3;
    m_gh = 0;
  endtask

  task automatic m_pred(input int pc, output logic p, output logic g, output logic l);
    g = m_g[m_gh] >= 2;
    l = m_l[m_lht[(pc >> 2) & 3]] >= 4;
    p = (m_sel[(pc >> 2) & 15] >= 2) ? g : l;
  endtask

  task automatic m_update(input int pc, input logic t, input logic g, input logic l);
    int li;
    li = m_lht[(pc >> 2) & 3];
    m_g[m_gh] = t ? ((m_g[m_gh] < 3) ? m_g[m_gh] + 1 : 3) : ((m_g[m_gh] > 0) ? m_g[m_gh] - 1 : 0);
    m_l[li] = t ? ((m_l[li] < 7) ? m_l[li] + 1 : 7) : ((m_l[li] > 0) ? m_l[li] - 1 : 0);
    m_lht[(pc >> 2) & 3] = ((li << 1) | int'(t)) & 7;
    m_gh = ((m_gh << 1) | int'(t)) & 7;
    if (g != l) begin
      if (g == t) m_sel[(pc >> 2) & 15] = (m_sel[(pc >> 2) & 15] < 3) ? m_sel[(pc >> 2) & 15] + 1 : 3;
      else        m_sel[(pc >> 2) & 15] = (m_sel[(pc >> 2) & 15] > 0) ? m_sel[(pc >> 2) & 15] - 1 : 0;
    end
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic check_pc(input int pc, input string phase);
    logic p, g, l;
    m_pred(pc, p, g, l);
    fe_pc = PC_W'(pc);
    #1;
    chk({"R1 R2 final ", phase}, pred_taken, p);
    chk({"R3 R6 global ", phase}, pred_global, g);
    chk({"R4 R5 local ", phase}, pred_local, l);
  endtask

  // R9: predict, then resolve in the same cycle; effect appears after the edge
  task automatic step(input int pc, input logic t, input logic force_en, input logic fg, input logic fl);
    logic p, g, l;
    @(negedge clk);
    check_pc(pc, "R9 step");
    m_pred(pc, p, g, l);
    if (force_en) begin g = fg; l = fl; end
    rs_valid = 1; rs_pc = PC_W'(pc); rs_taken = t; rs_pred_global = g; rs_pred_local = l;
    @(posedge clk);
    m_update(pc, t, g, l);
    #1 rs_valid = 0;
  endtask

  // {pc word[5:0], outcome}
  localparam logic [6:0] VEC [32] = '{
    {6'd3,1'b1},{6'd3,1'b1},{6'd3,1'b1},{6'd3,1'b1},{6'd3,1'b1},{6'd3,1'b1},{6'd3,1'b1},{6'd3,1'b1},
    {6'd3,1'b1},{6'd3,1'b1},{6'd3,1'b0},{6'd3,1'b1},{6'd5,1'b1},{6'd5,1'b0},{6'd5,1'b1},{6'd5,1'b0},
    {6'd6,1'b0},{6'd6,1'b0},{6'd6,1'b0},{6'd6,1'b0},{6'd6,1'b0},{6'd6,1'b0},{6'd7,1'b1},{6'd9,1'b0},
    {6'd3,1'b1},{6'd7,1'b0},{6'd21,1'b1},{6'd5,1'b1},{6'd9,1'b1},{6'd6,1'b0},{6'd3,1'b1},{6'd21,1'b0}};

  initial begin
    repeat (40000) @(posedge clk);
    total++; fails++;
    $display("FAIL all requirements: watchdog act=running exp=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic sp, sg, sl;
    m_reset();
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R8: reset state gives not-taken everywhere
    @(negedge clk);
    for (int pc = 0; pc < 64; pc += 12) begin
      fe_pc = PC_W'(pc); #1;
      chk("R8 reset final", pred_taken, 1'b0);
      chk("R8 reset global", pred_global, 1'b0);
      chk("R8 reset local", pred_local, 1'b0);
    end
    for (int i = 0; i < 32; i++) step(int'(VEC[i][6:1]) << 2, VEC[i][0], 0, 0, 0);
    // R2: forced disagreement drives the selector both ways
    for (int i = 0; i < 4; i++) step(36, 1'b1, 1, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) step(36, 1'b0, 1, 1'b0, 1'b1);
    for (int i = 0; i < 3; i++) step(36, 1'b1, 1, 1'b1, 1'b1);
    for (int i = 0; i < 3; i++) step(40, 1'b0, 1, 1'b1, 1'b0);
    for (int i = 0; i < 6; i++) step(40, i[0], 1, 1'b1, 1'b0);
    // R7: resolve fields toggled with valid low leave every prediction unchanged
    @(negedge clk);
    fe_pc = 16'd12; #1;
    sp = pred_taken; sg = pred_global; sl = pred_local;
    rs_pc = 16'd12; rs_pred_global = 1; rs_pred_local = 0;
    for (int i = 0; i < 6; i++) begin
      rs_taken = i[0];
      @(negedge clk);
    end
    #1;
    chk("R7 idle final", pred_taken, sp);
    chk("R7 idle global", pred_global, sg);
    chk("R7 idle local", pred_local, sl);
    for (int pc = 0; pc < 64; pc += 4) check_pc(pc, "R7 sweep");
    // R8: reset again after training
    rst = 1; m_reset();
    @(posedge clk); #1 rst = 0;
    @(negedge clk);
    check_pc(12, "R8 re-reset");
    chk("R8 re-reset zero", pred_taken | pred_global | pred_local, 1'b0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule